// File: doc/BRIEF.md
# Multi-Format Audio Serial Transmitter

This block serializes one stereo sample pair per frame onto a single data line. It follows an externally generated bit clock and a left/right (or frame-sync) clock. Five framings are supported: left-justified, right-justified, I2S, and two DSP-style framings in which both words follow a sync pulse back to back. Words are 16, 20, 24 or 32 bits long and are sent MSB first. A control pin selects whether the data line changes on the falling or the rising bit-clock edge. The falling edge is the default.

The bit clock and left/right clock are plain inputs that are synchronous to, and much slower than, the system clock `clk`. The block detects the launch edge of the bit clock in the `clk` domain. It drives `sdata` from a register that updates in the `clk` cycle after the edge is seen. Samples arrive on a valid/ready port. `s_ready` is high for exactly one `clk` cycle at each frame start, and the pair is taken if `s_valid` is high in that cycle. Upstream back-pressure rule: the source holds `s_valid` and the pair until the transfer. Any change at the input outside the frame-start cycle has no effect. The configuration pins are expected to stay static while reset is released.

Top module: `audio_ser_tx`

## Requirements
- R1: While `rst_n` is low, `sdata` and `s_ready` are 0.
- R2: `sdata` changes only in the `clk` cycle after a launch edge. With `launch_rise`=0 a launch edge is a 1-to-0 transition of `bclk`. With `launch_rise`=1 it is a 0-to-1 transition.
- R3: The word length is set by `wsel`: 0=16, 1=20, 2=24, 3=32 bits. A sample occupies bits W-1..0 of its input, the bits above are ignored, and the sample is sent MSB first.
- R4: `fmt`=0 (left-justified): `lrclk` high carries the left word and low carries the right word. The MSB is sent at the launch edge where the new `lrclk` level is first seen (slot 0 of the half-frame).
- R5: `fmt`=2 (I2S): `lrclk` low carries the left word and high carries the right word. The MSB is sent in slot 1, one bit clock after the level change.
- R6: `fmt`=1 (right-justified): `lrclk` high carries left. The word is placed so its LSB occupies the last slot before the next `lrclk` change, using the length of the previous half-frame. The output stays low until one whole half-frame has been measured.
- R7: `fmt`=1 with `wsel`=3 is an unsupported combination, and `sdata` stays low.
- R8: `fmt`=4 (DSP, no delay): a frame starts at the launch edge where a rising `lrclk` is first seen. The left word starts in slot 0 and the right word follows immediately. A falling `lrclk` has no effect.
- R9: `fmt`=3 (DSP, one-bit delay): the same as R8, but the left MSB is in slot 1.
- R10: Slots that carry no sample bit drive `sdata` low.
- R11: `s_ready` pulses once per frame start. A frame starts at the change into the left level in the stereo formats and at a rising sync in the DSP formats. The pair taken then is sent unchanged for the whole frame, even if the inputs change.
- R12: If `s_valid` is low at a frame start, zeros are sent for that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fmt | input | 3 | Framing: 0 LJ, 1 RJ, 2 I2S, 3 DSP delayed, 4 DSP no delay |
| wsel | input | 2 | Word length select |
| launch_rise | input | 1 | 1: data launched on rising `bclk` |
| bclk | input | 1 | Bit clock, sampled in `clk` domain |
| lrclk | input | 1 | Left/right clock or frame sync |
| s_valid | input | 1 | Sample pair valid |
| s_ready | output | 1 | Pair accepted this cycle if valid |
| s_left | input | 32 | Left sample, right-aligned |
| s_right | input | 32 | Right sample, right-aligned |
| sdata | output | 1 | Serial data |

## Verification
The sweep covers every framing, word length and launch polarity, with half-frames a few bits longer than the word. Because of that slack, a design that misplaces the word by one slot shows up as wrong bits at both ends. This applies to an I2S MSB without its delay, a right-justified LSB that falls one slot early, and a DSP-A frame that starts without its one-bit offset. The sync is held high for two bit clocks, so a DSP framer that restarts on the falling sync would reset its slot count. The input pair is inverted right after each frame start, which exposes a holder that forwards live inputs. One frame per configuration is sent without `s_valid`, which exposes a design that replays the old pair instead of sending zeros. The 32-bit right-justified case must stay silent.

// File: rtl/atx_pkg.sv
package atx_pkg;
  localparam int unsigned SAMPLE_W = 32;

  typedef enum logic [2:0] {
    FMT_LJ   = 3'd0,
    FMT_RJ   = 3'd1,
    FMT_I2S  = 3'd2,
    FMT_DSPA = 3'd3,
    FMT_DSPB = 3'd4
  } atx_fmt_e;

  function automatic logic [5:0] word_len(input logic [1:0] sel);
    case (sel)
      2'd0:    return 6'd16;
      2'd1:    return 6'd20;
      2'd2:    return 6'd24;
      default: return 6'd32;
    endcase
  endfunction
endpackage

// File: rtl/atx_edge.sv
module atx_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic launch_rise,
  input  logic bclk,
  output logic launch
);
  logic bclk_d;

  // reset value = the level from which no launch edge can be seen
  always_ff @(posedge clk) begin
    if (!rst_n) bclk_d <= launch_rise;
    else        bclk_d <= bclk;
  end

  assign launch = launch_rise ? (~bclk_d & bclk) : (bclk_d & ~bclk);
endmodule

// File: rtl/atx_framer.sv
module atx_framer
  import atx_pkg::*;
#(
  parameter int unsigned SLOT_W = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       launch,
  input  logic       lrclk,
  input  atx_fmt_e   fmt_e,
  input  logic [1:0] wsel,
  output logic       frame_start,
  output logic       bit_vld,
  output logic       bit_right,
  output logic [4:0] bit_idx
);
  localparam int unsigned KW = SLOT_W + 1;
  localparam logic [SLOT_W-1:0] KMAX = '1;

  logic              lr_last, started, n_ok;
  logic [SLOT_W-1:0] k_q;
  logic [KW-1:0]     n_q;

  logic              dsp, edge_seen, started_now, nok_now, left_lvl;
  logic [SLOT_W-1:0] k_now;
  logic [KW-1:0]     n_now, kk, wl, idx_w, j;

  always_comb begin
    dsp         = (fmt_e == FMT_DSPA) || (fmt_e == FMT_DSPB);
    edge_seen   = dsp ? (lrclk & ~lr_last) : (lrclk ^ lr_last);
    k_now       = edge_seen ? '0 : ((k_q == KMAX) ? k_q : k_q + 1'b1);
    started_now = started | edge_seen;
    n_now       = edge_seen ? ({1'b0, k_q} + KW'(1)) : n_q;
    nok_now     = edge_seen ? started : n_ok;
    left_lvl    = (fmt_e != FMT_I2S);
    kk          = {1'b0, k_now};
    wl          = KW'(word_len(wsel));
    j           = kk;
    bit_vld     = 1'b0;
    bit_right   = 1'b0;
    idx_w       = '0;
    case (fmt_e)
      FMT_LJ: begin
        bit_vld   = started_now && (kk < wl);
        bit_right = ~lrclk;
        idx_w     = wl - KW'(1) - kk;
      end
      FMT_I2S: begin
        bit_vld   = started_now && (kk >= KW'(1)) && (kk <= wl);
        bit_right = lrclk;
        idx_w     = wl - kk;
      end
      FMT_RJ: begin
        bit_vld   = started_now && nok_now && (wsel != 2'd3) &&
                    (kk < n_now) && ((kk + wl) >= n_now);
        bit_right = ~lrclk;
        idx_w     = n_now - KW'(1) - kk;
      end
      FMT_DSPA, FMT_DSPB: begin
        j         = (fmt_e == FMT_DSPA) ? (kk - KW'(1)) : kk;
        bit_vld   = started_now && (fmt_e == FMT_DSPB || kk >= KW'(1)) &&
                    (j < (wl << 1));
        bit_right = (j >= wl);
        idx_w     = bit_right ? ((wl << 1) - KW'(1) - j) : (wl - KW'(1) - j);
      end
      default: bit_vld = 1'b0;
    endcase
    bit_idx     = idx_w[4:0];
    frame_start = launch && edge_seen && (dsp || (lrclk == left_lvl));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lr_last <= 1'b0;
      started <= 1'b0;
      n_ok    <= 1'b0;
      k_q     <= '0;
      n_q     <= '0;
    end else if (launch) begin
      lr_last <= lrclk;
      started <= started_now;
      n_ok    <= nok_now;
      k_q     <= k_now;
      n_q     <= n_now;
    end
  end

  // R3: a driven bit always indexes inside the selected word
  p_idx_in_word_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (launch && bit_vld) |-> ({{(KW-5){1'b0}}, bit_idx} < wl));
endmodule

// File: rtl/atx_hold.sv
module atx_hold
  import atx_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                frame_start,
  input  logic                s_valid,
  input  logic [SAMPLE_W-1:0] s_left,
  input  logic [SAMPLE_W-1:0] s_right,
  output logic                s_ready,
  output logic [SAMPLE_W-1:0] cur_l,
  output logic [SAMPLE_W-1:0] cur_r
);
  logic [SAMPLE_W-1:0] held_l, held_r;

  assign s_ready = frame_start;
  assign cur_l   = frame_start ? (s_valid ? s_left  : '0) : held_l;
  assign cur_r   = frame_start ? (s_valid ? s_right : '0) : held_r;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held_l <= '0;
      held_r <= '0;
    end else if (frame_start) begin
      held_l <= cur_l;
      held_r <= cur_r;
    end
  end

  p_pair_frozen_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> $stable({held_l, held_r}));

  p_underrun_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && !s_valid) |=> (held_l == '0 && held_r == '0));
endmodule

// File: rtl/audio_ser_tx.sv
module audio_ser_tx
  import atx_pkg::*;
#(
  parameter int unsigned SLOT_W = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  fmt,
  input  logic [1:0]  wsel,
  input  logic        launch_rise,
  input  logic        bclk,
  input  logic        lrclk,
  input  logic        s_valid,
  output logic        s_ready,
  input  logic [31:0] s_left,
  input  logic [31:0] s_right,
  output logic        sdata
);
  atx_fmt_e            fmt_e;
  logic                launch, frame_start, bit_vld, bit_right;
  logic [4:0]          bit_idx;
  logic [SAMPLE_W-1:0] cur_l, cur_r;
  logic                bit_val;

  assign fmt_e = atx_fmt_e'(fmt);

  atx_edge u_edge (
    .clk(clk), .rst_n(rst_n), .launch_rise(launch_rise),
    .bclk(bclk), .launch(launch)
  );

  atx_framer #(.SLOT_W(SLOT_W)) u_framer (
    .clk(clk), .rst_n(rst_n), .launch(launch), .lrclk(lrclk),
    .fmt_e(fmt_e), .wsel(wsel), .frame_start(frame_start),
    .bit_vld(bit_vld), .bit_right(bit_right), .bit_idx(bit_idx)
  );

  atx_hold u_hold (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
    .s_valid(s_valid), .s_left(s_left), .s_right(s_right),
    .s_ready(s_ready), .cur_l(cur_l), .cur_r(cur_r)
  );

  assign bit_val = bit_right ? cur_r[bit_idx] : cur_l[bit_idx];

  always_ff @(posedge clk) begin
    if (!rst_n)      sdata <= 1'b0;
    else if (launch) sdata <= bit_vld & bit_val;
  end

  p_quiet_between_launches_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !launch |=> $stable(sdata));

  p_rj32_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fmt_e == FMT_RJ && wsel == 2'd3 && launch) |=> !sdata);
endmodule

// File: tb/audio_ser_tx_tb.sv
module audio_ser_tx_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  fmt = 3'd0;
  logic [1:0]  wsel = 2'd0;
  logic        launch_rise = 1'b0;
  logic        bclk = 1'b1;
  logic        lrclk = 1'b0;
  logic        s_valid = 1'b0;
  logic        s_ready;
  logic [31:0] s_left = '0;
  logic [31:0] s_right = '0;
  logic        sdata;

  int n_checks = 0;
  int n_err = 0;
  int rdy_cnt = 0;
  int hs_cnt = 0;

  always #5 clk = ~clk;

  audio_ser_tx dut_i (
    .clk(clk), .rst_n(rst_n), .fmt(fmt), .wsel(wsel),
    .launch_rise(launch_rise), .bclk(bclk), .lrclk(lrclk),
    .s_valid(s_valid), .s_ready(s_ready), .s_left(s_left),
    .s_right(s_right), .sdata(sdata)
  );

  always @(posedge clk) begin
    if (rst_n && s_ready) rdy_cnt <= rdy_cnt + 1;
    if (rst_n && s_ready && s_valid) hs_cnt <= hs_cnt + 1;
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h (fmt=%0d wsel=%0d rise=%0d)",
               req, act, exp, fmt, wsel, launch_rise);
    end
  endtask

  // Expected bit of slot p in a frame, straight from R4..R10
  function automatic logic exp_bit(input int f, input int w, input int p, input int hn,
                                   input logic [31:0] l, input logic [31:0] r,
                                   output bit used);
    int k, half, j;
    used = 1'b0;
    half = p / hn;
    k    = p % hn;
    case (f)
      0: if (k < w) begin used = 1'b1; return half != 0 ? r[w-1-k] : l[w-1-k]; end
      2: if (k >= 1 && k <= w) begin used = 1'b1; return half != 0 ? r[w-k] : l[w-k]; end
      1: if (w != 32 && k >= hn - w) begin
           used = 1'b1; return half != 0 ? r[hn-1-k] : l[hn-1-k];
         end
      default: begin
        j = (f == 3) ? p - 1 : p;
        if (j >= 0 && j < 2 * w) begin
          used = 1'b1; return j < w ? l[w-1-j] : r[2*w-1-j];
        end
      end
    endcase
    return 1'b0;
  endfunction

  task automatic bit_period(input logic lv, input bit chk, input logic expv,
                            input string req);
    logic a;
    @(posedge clk); #1;
    bclk  = launch_rise;
    lrclk = lv;
    @(posedge clk); @(posedge clk); #1;
    bclk = !launch_rise;
    a = sdata;
    if (chk) check(a == expv, req, {31'd0, a}, {31'd0, expv});
    @(posedge clk); @(posedge clk); #1;
    if (chk) check(sdata == a, "R2 hold between launches", {31'd0, sdata}, {31'd0, a});
  endtask

  task automatic run_cfg(input int f, input int ws, input bit rise, input int cfg);
    int w, hn, flen, rdy0, hs0;
    bit left_lv, dsp, used;
    logic [31:0] l, r, cv;
    logic e;
    string req;
    w    = (ws == 3) ? 32 : 16 + 4 * ws;
    dsp  = (f >= 3);
    hn   = w + 3;
    flen = dsp ? 2 * w + 3 : 2 * hn;
    left_lv = (f != 2);
    cv = 32'(cfg);
    @(posedge clk); #1;
    rst_n = 1'b0;
    fmt = 3'(f); wsel = 2'(ws); launch_rise = rise;
    bclk = !rise;
    lrclk = dsp ? 1'b0 : !left_lv;
    s_valid = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check(sdata == 1'b0 && s_ready == 1'b0, "R1 reset outputs",
          {30'd0, sdata, s_ready}, 32'd0);
    rst_n = 1'b1;
    rdy0 = rdy_cnt; hs0 = hs_cnt;
    bit_period(dsp ? 1'b0 : !left_lv, 1'b0, 1'b0, "");
    for (int fr = 0; fr < 4; fr++) begin
      l = 32'hC0DE_5A3C ^ (cv * 32'h0101_0107) ^ (32'(fr) * 32'h9E37_79B9);
      r = ~l ^ 32'h1234_5678 ^ 32'(fr);
      s_left = l; s_right = r;
      s_valid = (fr != 2);
      if (fr == 2) begin l = '0; r = '0; end
      for (int p = 0; p < flen; p++) begin
        logic lv;
        if (dsp) lv = (p < 2);
        else     lv = (p / hn == 0) ? left_lv : !left_lv;
        e = exp_bit(f, w, p, hn, l, r, used);
        if (fr == 2) req = "R12 underrun zeros";
        else if (!used) req = "R10 idle slot low";
        else case (f)
          0: req = "R4/R3 left-justified bit";
          1: req = "R6 right-justified bit";
          2: req = "R5 I2S bit";
          3: req = "R9 DSP delayed bit";
          default: req = "R8 DSP bit";
        endcase
        if (f == 1 && w == 32) req = "R7 RJ 32 silent";
        bit_period(lv, fr >= 1, e, req);
        if (p == 0) begin
          // R11: inputs change mid-frame; the latched pair must be used
          s_left = ~s_left; s_right = ~s_right;
        end
      end
    end
    check(rdy_cnt - rdy0 == 4, "R11 one ready pulse per frame",
          32'(rdy_cnt - rdy0), 32'd4);
    check(hs_cnt - hs0 == 3, "R11 handshakes", 32'(hs_cnt - hs0), 32'd3);
  endtask

  initial begin
    int cfg;
    cfg = 0;
    repeat (2) @(posedge clk);
    for (int f = 0; f < 5; f++)
      for (int ws = 0; ws < 4; ws++)
        for (int rb = 0; rb < 2; rb++) begin
          run_cfg(f, ws, rb[0], cfg);
          cfg++;
        end
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_checks++;
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end
endmodule